// File: doc/BRIEF.md
# Condition Flag Register Unit

This block owns the condition flags of a small 8-bit processor core and the short arithmetic that produces them for a few operations. It keeps a flag byte with zero (Z), subtract (N), half-carry (H) and carry (C). Each of these flags also drives its own output pin, so that branch and return logic can test a condition without decoding the byte.

The execute stage asserts an update strobe together with an operation select. In direct mode it supplies a two-bit request for each flag, which sets the flag, clears it or leaves it as it is. In the other three modes the unit computes the new flags on its own:
- An exclusive-OR of the accumulator with an operand byte.
- A stack pointer plus a signed byte offset, with the 16-bit sum written to a register-pair result.
- A 16-bit pop into the accumulator/flag pair.

The accumulator and pair results are held in output registers next to the flags.

Top module: `flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `flags_q`, `acc_q` and `pair_q` to zero on the next rising edge, whatever the other inputs are.
- R2: The flag byte places Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. The outputs `flag_z`, `flag_n`, `flag_h` and `flag_c` always equal those bits of `flags_q`.
- R3: With `op_sel` = 0 (direct) and the strobe high, each flag follows its own two-bit request in `flag_req`. Z uses bits [7:6], N uses [5:4], H uses [3:2] and C uses [1:0]. Code 2'b11 sets the flag, 2'b10 clears it, and 2'b00 or 2'b01 leaves it unchanged. `acc_q` and `pair_q` keep their values.
- R4: With `op_sel` = 1 (exclusive-OR) and the strobe high, `acc_q` becomes `acc_in` XOR `operand[7:0]`. Z is set exactly when that result is zero, and N, H and C are cleared.
- R5: With `op_sel` = 2 (stack pointer plus offset) and the strobe high, `pair_q` becomes `sp_in` plus the sign-extended `offset`, truncated to 16 bits.
- R6: In the same mode, H is set when `sp_in[3:0]` + `offset[3:0]` is 0x10 or more, and C is set when `sp_in[7:0]` + `offset` is 0x100 or more. Both sums treat their operands as unsigned. Z and N are cleared.
- R7: With `op_sel` = 3 (pop) and the strobe high, `acc_q` becomes `pop_val[15:8]` and the flag byte becomes `pop_val[7:0]` AND 0xF0.
- R8: Bits 3..0 of `flags_q` read as zero at all times.
- R9: While the strobe is low, `flags_q`, `acc_q` and `pair_q` do not change, whatever the operation select and operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe; state changes only while high |
| op_sel | input | 2 | 0 direct, 1 exclusive-OR, 2 stack pointer plus offset, 3 pop |
| flag_req | input | 8 | Per-flag two-bit requests for direct mode |
| acc_in | input | 8 | Accumulator operand |
| operand | input | 16 | Operand; the low byte feeds the exclusive-OR |
| sp_in | input | 16 | Stack pointer operand |
| offset | input | 8 | Signed byte offset |
| pop_val | input | 16 | Popped word, accumulator in the high byte |
| flags_q | output | 8 | Registered flag byte |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |
| acc_q | output | 8 | Registered accumulator result |
| pair_q | output | 16 | Registered register-pair result |

## Verification
The assertions assume that the inputs are stable and known at every rising edge and that `op_sel` holds one of the four defined codes while the strobe is high. The bench changes every input only on falling edges and draws `op_sel` from the four codes alone. It drives known values from time zero, so reset is the first thing sampled. The stimulus also runs idle cycles in which the operands and select change while the strobe is low, to check that the register contents hold.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_XOR    = 2'd1,
    OP_SP_OFS = 2'd2,
    OP_POP_AF = 2'd3
  } flag_op_e;

  // per-flag request codes; 2'b00 and 2'b01 both keep the flag
  localparam logic [1:0] REQ_CLR = 2'b10;
  localparam logic [1:0] REQ_SET = 2'b11;

  localparam int NUM_FLAGS = 4;
  localparam int BIT_Z = 7;
  localparam int BIT_N = 6;
  localparam int BIT_H = 5;
  localparam int BIT_C = 4;

endpackage

// File: rtl/flagu_field.sv
module flagu_field
  import flagu_pkg::*;
(
  input  logic       cur,
  input  logic [1:0] req,
  output logic       nxt
);

  // R3: set, clear or keep a single flag
  always_comb begin
    case (req)
      REQ_CLR: nxt = 1'b0;
      REQ_SET: nxt = 1'b1;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/flagu_calc.sv
module flagu_calc
  import flagu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  flag_op_e                   op,
  input  logic [DATA_W-1:0]          flags_cur,
  input  logic [2*NUM_FLAGS-1:0]     flag_req,
  input  logic [DATA_W-1:0]          acc_in,
  input  logic [WORD_W-1:0]          operand,
  input  logic [WORD_W-1:0]          sp_in,
  input  logic [DATA_W-1:0]          offset,
  input  logic [WORD_W-1:0]          pop_val,
  output logic [DATA_W-1:0]          flags_nxt,
  output logic [DATA_W-1:0]          acc_nxt,
  output logic                       acc_we,
  output logic [WORD_W-1:0]          pair_nxt,
  output logic                       pair_we
);

  localparam int NIB_W  = DATA_W / 2;
  localparam int EXT_W  = WORD_W - DATA_W;
  localparam int LOW_W  = DATA_W - NUM_FLAGS;

  // direct-mode per-flag update, Z first
  logic [NUM_FLAGS-1:0] direct_nib;
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_field
    flagu_field u_field (
      .cur (flags_cur[DATA_W-1-i]),
      .req (flag_req[2*NUM_FLAGS-1-2*i -: 2]),
      .nxt (direct_nib[NUM_FLAGS-1-i])
    );
  end

  // exclusive-OR result
  logic [DATA_W-1:0] xor_res;
  assign xor_res = acc_in ^ operand[DATA_W-1:0];

  // stack pointer plus signed offset; carries from unsigned low parts
  logic [WORD_W-1:0] ofs_ext;
  logic [WORD_W-1:0] sp_sum;
  logic [NIB_W:0]    nib_sum;
  logic [DATA_W:0]   byte_sum;
  assign ofs_ext  = {{EXT_W{offset[DATA_W-1]}}, offset};
  assign sp_sum   = sp_in + ofs_ext;
  assign nib_sum  = {1'b0, sp_in[NIB_W-1:0]} + {1'b0, offset[NIB_W-1:0]};
  assign byte_sum = {1'b0, sp_in[DATA_W-1:0]} + {1'b0, offset};

  logic [NUM_FLAGS-1:0] nib;
  always_comb begin
    nib      = direct_nib;
    acc_nxt  = acc_in;
    acc_we   = 1'b0;
    pair_nxt = sp_sum;
    pair_we  = 1'b0;
    case (op)
      OP_XOR: begin
        acc_nxt = xor_res;
        acc_we  = 1'b1;
        nib     = {(xor_res == '0), 3'b000};
      end
      OP_SP_OFS: begin
        pair_we = 1'b1;
        nib     = {2'b00, nib_sum[NIB_W], byte_sum[DATA_W]};
      end
      OP_POP_AF: begin
        acc_nxt = pop_val[WORD_W-1 -: DATA_W];
        acc_we  = 1'b1;
        nib     = pop_val[DATA_W-1 -: NUM_FLAGS];
      end
      default: nib = direct_nib;
    endcase
  end

  // R8: the low part is never taken from any source
  assign flags_nxt = {nib, {LOW_W{1'b0}}};

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_sel,
  input  logic [7:0]        flag_req,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [DATA_W-1:0] offset,
  input  logic [WORD_W-1:0] pop_val,
  output logic [DATA_W-1:0] flags_q,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_h,
  output logic              flag_c,
  output logic [DATA_W-1:0] acc_q,
  output logic [WORD_W-1:0] pair_q
);

  localparam int LOW_W = DATA_W - NUM_FLAGS;

  logic [DATA_W-1:0] flags_nxt;
  logic [DATA_W-1:0] acc_nxt;
  logic [WORD_W-1:0] pair_nxt;
  logic              acc_we;
  logic              pair_we;

  flagu_calc #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_calc (
    .op        (flag_op_e'(op_sel)),
    .flags_cur (flags_q),
    .flag_req  (flag_req),
    .acc_in    (acc_in),
    .operand   (operand),
    .sp_in     (sp_in),
    .offset    (offset),
    .pop_val   (pop_val),
    .flags_nxt (flags_nxt),
    .acc_nxt   (acc_nxt),
    .acc_we    (acc_we),
    .pair_nxt  (pair_nxt),
    .pair_we   (pair_we)
  );

  // R1, R9: registered state
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      acc_q   <= '0;
      pair_q  <= '0;
    end else if (upd_en) begin
      flags_q <= flags_nxt;
      if (acc_we)  acc_q  <= acc_nxt;
      if (pair_we) pair_q <= pair_nxt;
    end
  end

  // R2: condition outputs
  assign flag_z = flags_q[BIT_Z];
  assign flag_n = flags_q[BIT_N];
  assign flag_h = flags_q[BIT_H];
  assign flag_c = flags_q[BIT_C];

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_q == '0) && (acc_q == '0) && (pair_q == '0));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags_q) && $stable(acc_q) && $stable(pair_q));

  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    flags_q[LOW_W-1:0] == '0);

  a_r4_xor_flags: assert property (@(posedge clk) disable iff (rst)
    upd_en && op_sel == 2'd1 |=> !flag_n && !flag_h && !flag_c && (flag_z == (acc_q == '0)));

  a_r6_spofs_zn_clear: assert property (@(posedge clk) disable iff (rst)
    upd_en && op_sel == 2'd2 |=> !flag_z && !flag_n && $stable(acc_q));

  a_r7_pop_masks: assert property (@(posedge clk) disable iff (rst)
    upd_en && op_sel == 2'd3 |=> flags_q[DATA_W-1 -: NUM_FLAGS] == $past(pop_val[DATA_W-1 -: NUM_FLAGS]));

  a_r3_direct_keeps_data: assert property (@(posedge clk) disable iff (rst)
    upd_en && op_sel == 2'd0 |=> $stable(acc_q) && $stable(pair_q));

endmodule

// File: tb/test_flag_unit.sv
module test_flag_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          due;
    logic [7:0]  flags;
    logic [7:0]  acc;
    logic [15:0] pair;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [7:0]  flag_req = 8'h00;
  logic [7:0]  acc_in = 8'h00;
  logic [15:0] operand = 16'h0000;
  logic [15:0] sp_in = 16'h0000;
  logic [7:0]  offset = 8'h00;
  logic [15:0] pop_val = 16'h0000;
  logic [7:0]  flags_q;
  logic        flag_z, flag_n, flag_h, flag_c;
  logic [7:0]  acc_q;
  logic [15:0] pair_q;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  exp_t sb_q[$];

  logic [7:0]  m_flags = 8'h00;
  logic [7:0]  m_acc   = 8'h00;
  logic [15:0] m_pair  = 16'h0000;

  flag_unit i_flag_unit (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel), .flag_req(flag_req),
    .acc_in(acc_in), .operand(operand), .sp_in(sp_in), .offset(offset), .pop_val(pop_val),
    .flags_q(flags_q), .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c),
    .acc_q(acc_q), .pair_q(pair_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic req_apply(logic cur, logic [1:0] r);
    if (r == 2'b11) return 1'b1;
    if (r == 2'b10) return 1'b0;
    return cur;
  endfunction

  // driver: apply one cycle of stimulus and push the model's expectation
  task automatic drive(input logic r, input logic en, input logic [1:0] op,
                       input logic [7:0] req, input logic [7:0] a, input logic [15:0] opd,
                       input logic [15:0] sp, input logic [7:0] ofs, input logic [15:0] pv,
                       input string tag);
    exp_t e;
    int   ext;
    @(negedge clk);
    rst = r; upd_en = en; op_sel = op; flag_req = req; acc_in = a;
    operand = opd; sp_in = sp; offset = ofs; pop_val = pv;
    if (r) begin
      m_flags = 8'h00; m_acc = 8'h00; m_pair = 16'h0000;
    end else if (en) begin
      case (op)
        2'd0: begin
          m_flags[7] = req_apply(m_flags[7], req[7:6]);
          m_flags[6] = req_apply(m_flags[6], req[5:4]);
          m_flags[5] = req_apply(m_flags[5], req[3:2]);
          m_flags[4] = req_apply(m_flags[4], req[1:0]);
        end
        2'd1: begin
          m_acc   = a ^ opd[7:0];
          m_flags = (m_acc == 8'h00) ? 8'h80 : 8'h00;
        end
        2'd2: begin
          ext     = (ofs >= 8'd128) ? int'(ofs) - 256 : int'(ofs);
          m_pair  = 16'(int'(sp) + ext);
          m_flags = 8'h00;
          if (int'(sp[3:0]) + int'(ofs[3:0]) >= 16) m_flags[5] = 1'b1;
          if (int'(sp[7:0]) + int'(ofs) >= 256) m_flags[4] = 1'b1;
        end
        default: begin
          m_acc   = pv[15:8];
          m_flags = pv[7:0] & 8'hF0;
        end
      endcase
    end
    e.due = cyc + 1; e.flags = m_flags; e.acc = m_acc; e.pair = m_pair; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare results one cycle after they were driven
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (flags_q !== e.flags || acc_q !== e.acc || pair_q !== e.pair) begin
          fails++;
          $display("FAIL %s flags=%h acc=%h pair=%h expected flags=%h acc=%h pair=%h",
                   e.tag, flags_q, acc_q, pair_q, e.flags, e.acc, e.pair);
        end
        checks++; // R2: pin positions of the condition bits
        if ({flag_z, flag_n, flag_h, flag_c} !== e.flags[7:4]) begin
          fails++;
          $display("FAIL R2 bits=%b expected=%b", {flag_z, flag_n, flag_h, flag_c}, e.flags[7:4]);
        end
        checks++; // R8: low part reads zero
        if (flags_q[3:0] !== 4'h0) begin
          fails++;
          $display("FAIL R8 low=%h expected=0", flags_q[3:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with busy inputs
    drive(1, 1, 2'd3, 8'hFF, 8'h5A, 16'h1234, 16'hFFFF, 8'h7F, 16'hABCD, "R1");
    drive(1, 1, 2'd2, 8'hFF, 8'h5A, 16'h1234, 16'h00FF, 8'h01, 16'hFFFF, "R1");
    // R3: set all, clear some, keep codes 00 and 01
    drive(0, 1, 2'd0, 8'hFF, 8'h11, 16'h2222, 16'h3333, 8'h44, 16'h5555, "R3");
    drive(0, 1, 2'd0, 8'b10_00_10_01, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R3");
    drive(0, 1, 2'd0, 8'b01_11_00_11, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R3");
    drive(0, 1, 2'd0, 8'b00_01_00_01, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R3");
    // R4: zero and nonzero results, upper operand bits ignored
    drive(0, 1, 2'd1, 8'h00, 8'hA5, 16'hFFA5, 16'h0, 8'h0, 16'h0, "R4");
    drive(0, 1, 2'd0, 8'hFF, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R3");
    drive(0, 1, 2'd1, 8'h00, 8'hF0, 16'h000F, 16'h0, 8'h0, 16'h0, "R4");
    // R7: pop with low bits set
    drive(0, 1, 2'd3, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'h12FF, "R7");
    drive(0, 1, 2'd3, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'hFE0F, "R7");
    // R5, R6: boundary offsets
    drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'h000F, 8'h01, 16'h0, "R6");
    drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'h00FF, 8'h01, 16'h0, "R6");
    drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'h0000, 8'hFF, 16'h0, "R5");
    drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'hFFFF, 8'h7F, 16'h0, "R5");
    drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'h0000, 8'h80, 16'h0, "R5");
    // R9: strobe low with changing inputs
    for (int k = 0; k < 8; k++)
      drive(0, 0, 2'(k), 8'hFF, 8'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 16'($urandom), "R9");
    // R5, R6: every offset with random stack pointers
    for (int k = 0; k < 256; k++)
      drive(0, 1, 2'd2, 8'h00, 8'h00, 16'h0, 16'($urandom), 8'(k), 16'h0, "R6");
    // mixed random traffic
    for (int k = 0; k < 400; k++)
      drive(0, ($urandom % 4) != 0, 2'($urandom), 8'($urandom), 8'($urandom),
            16'($urandom), 16'($urandom), 8'($urandom), 16'($urandom), "R3");
    drive(1, 0, 2'd0, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R1");
    drive(0, 0, 2'd0, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0, "R9");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule